// File: doc/BRIEF.md
# Flag-Updating Integer ALU

This block is a 32-bit integer ALU for a simple processor datapath. Each operation arrives as one item on a valid/ready input stream, carrying two operands, an operation code and a flag-write enable. The computed value leaves on a valid/ready output stream, one item per accepted input and in the same order. The output item also carries a write-back qualifier that tells the register file whether to store the value.

Next to the data path, the block holds three status bits: sign, zero and overflow. These bits change only at the clock edge that accepts an operation whose flag-write enable is high. Add, subtract and compare read the operands as signed numbers and report signed overflow. AND, OR and XOR read them as raw bit patterns, so for these overflow is always cleared.

A condition evaluator reads the held flags together with a plain condition-select input and tells a branch unit whether a conditional jump is taken.

The input stream applies back-pressure: `in_ready` is high when the output register is empty or is being drained in the same cycle. An item is accepted on any rising edge where `in_valid` and `in_ready` are both high. An output item stays on the port, unchanged, until `out_ready` is seen high with `out_valid`.

Top module: `flagalu_core`

## Requirements
- R1: While reset is high and at the first edge after it, `out_valid`, `flag_sf`, `flag_zf` and `flag_of` are all 0.
- R2: Op code 0 (add) and op code 1 (subtract, a minus b) each produce the 32-bit truncated result on `out_result` with `out_wb` = 1, on the cycle after acceptance.
- R3: For add, subtract and compare, `flag_of` becomes 1 when the exact signed result, taken at 64-bit width, differs from the sign-extended 32-bit truncated result. Otherwise it becomes 0.
- R4: For every supported op, `flag_zf` becomes 1 exactly when the 32-bit result is zero. For the arithmetic ops, `flag_sf` becomes 1 exactly when the signed result is negative.
- R5: Op codes 2 (AND), 3 (OR) and 4 (XOR) produce the bitwise result with `out_wb` = 1. They set `flag_sf` to bit 31 of the result and clear `flag_of`.
- R6: The flags change only on an edge that accepts an item with `in_flag_we` = 1. An accepted item with `in_flag_we` = 0 still produces its result but leaves all three flags as they were.
- R7: Op code 5 (compare) sets the flags exactly as subtract does. Its output item carries `out_wb` = 0.
- R8: `cond_true` decodes `cond_sel` from the held flags as follows: 0 = ZF; 1 = not ZF; 2 = SF xor OF (less); 3 = not (SF xor OF) (greater or equal); 4 = ZF or (SF xor OF) (less or equal); 5 = not ZF and not (SF xor OF) (greater). Codes 6 and 7 give 0.
- R9: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_result` hold. Items leave in acceptance order.
- R10: Op codes 6 and 7 are unsupported. They produce `out_result` = 0 with `out_wb` = 0 and leave the flags unchanged even when `in_flag_we` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input item present |
| in_ready | output | 1 | Block can accept an item this cycle |
| in_op | input | 3 | Operation code |
| in_a | input | W | First operand |
| in_b | input | W | Second operand |
| in_flag_we | input | 1 | Commit flags for this item |
| out_valid | output | 1 | Output item present |
| out_ready | input | 1 | Consumer takes the output item |
| out_result | output | W | Computed value |
| out_wb | output | 1 | Result should be written back |
| flag_sf | output | 1 | Held sign flag |
| flag_zf | output | 1 | Held zero flag |
| flag_of | output | 1 | Held overflow flag |
| cond_sel | input | 3 | Condition select |
| cond_true | output | 1 | Selected condition holds |

## Verification
The bench aims at signed overflow at both ends of the range: the largest positive value plus one, and the most negative value minus one. A design that looked at the unsigned carry, or that ignored the operand signs, would show the wrong overflow there. It then runs a bitwise op straight after an overflowing add, which catches a design that keeps the stale overflow bit or that takes the sign from the signed-class logic. It also issues ops with the flag enable low and unsupported op codes with the enable high, which expose a design that writes the flags on every handshake. Finally, it streams a burst against an irregular `out_ready` pattern, which shows any result that is dropped, duplicated or reordered when the output register is stalled.

// File: rtl/flagalu_pkg.sv
`timescale 1ns/1ps
package flagalu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_CMP  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    CC_EQ   = 3'd0,
    CC_NE   = 3'd1,
    CC_LT   = 3'd2,
    CC_GE   = 3'd3,
    CC_LE   = 3'd4,
    CC_GT   = 3'd5,
    CC_NV6  = 3'd6,
    CC_NV7  = 3'd7
  } cc_e;

  typedef struct packed {
    logic sf;
    logic zf;
    logic of;
  } flags_t;

  localparam int OP_W = 3;
  localparam int CC_W = 3;

  function automatic logic op_is_arith(input logic [OP_W-1:0] op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_CMP);
  endfunction

  function automatic logic op_is_logic(input logic [OP_W-1:0] op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  endfunction

endpackage

// File: rtl/flagalu_arith.sv
`timescale 1ns/1ps
// Signed add/subtract with overflow detection. WIDE_CMP picks the
// detection method: wide exact sum compared with its truncation, or the
// operand/result sign rule.
module flagalu_arith #(
  parameter int W        = 32,
  parameter bit WIDE_CMP = 1'b1
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         ovf
);
  localparam int XW = 2 * W;

  generate
    if (WIDE_CMP) begin : g_wide
      logic [XW-1:0] xa, xb, xs, xt;
      always_comb begin
        xa  = {{W{a[W-1]}}, a};
        xb  = {{W{b[W-1]}}, b};
        xs  = sub ? (xa - xb) : (xa + xb);
        res = xs[W-1:0];
        xt  = {{W{xs[W-1]}}, xs[W-1:0]};
        ovf = (xs != xt);
      end
    end else begin : g_sign
      logic [W-1:0] bb;
      always_comb begin
        bb  = sub ? ~b : b;
        res = a + bb + {{(W-1){1'b0}}, sub};
        ovf = (a[W-1] == bb[W-1]) && (res[W-1] != a[W-1]);
      end
    end
  endgenerate
endmodule

// File: rtl/flagalu_logic.sv
`timescale 1ns/1ps
module flagalu_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   op,
  output logic [W-1:0] res
);
  import flagalu_pkg::*;

  always_comb begin
    unique case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/flagalu_flags.sv
`timescale 1ns/1ps
module flagalu_flags (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  flagalu_pkg::flags_t     nxt,
  output flagalu_pkg::flags_t     cur
);
  always_ff @(posedge clk) begin
    if (rst)     cur <= '0;
    else if (we) cur <= nxt;
  end
endmodule

// File: rtl/flagalu_cond.sv
`timescale 1ns/1ps
module flagalu_cond (
  input  flagalu_pkg::flags_t fl,
  input  logic [2:0]          sel,
  output logic                taken
);
  import flagalu_pkg::*;

  logic less;

  always_comb begin
    less = fl.sf ^ fl.of;
    unique case (sel)
      CC_EQ:   taken = fl.zf;
      CC_NE:   taken = !fl.zf;
      CC_LT:   taken = less;
      CC_GE:   taken = !less;
      CC_LE:   taken = fl.zf || less;
      CC_GT:   taken = !fl.zf && !less;
      default: taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/flagalu_core.sv
`timescale 1ns/1ps
module flagalu_core #(
  parameter int W        = 32,
  parameter bit WIDE_CMP = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [2:0]   in_op,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic         in_flag_we,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_result,
  output logic         out_wb,
  output logic         flag_sf,
  output logic         flag_zf,
  output logic         flag_of,
  input  logic [2:0]   cond_sel,
  output logic         cond_true
);
  import flagalu_pkg::*;

  logic [W-1:0] ar_res, lg_res, sel_res;
  logic         ar_ovf, ar_sub;
  logic         sel_wb, sel_legal;
  logic         accept, flag_we;
  flags_t       nxt_fl, cur_fl;

  assign ar_sub = (in_op == OP_SUB) || (in_op == OP_CMP);

  flagalu_arith #(.W(W), .WIDE_CMP(WIDE_CMP)) u_arith (
    .a(in_a), .b(in_b), .sub(ar_sub), .res(ar_res), .ovf(ar_ovf)
  );

  flagalu_logic #(.W(W)) u_logic (
    .a(in_a), .b(in_b), .op(in_op), .res(lg_res)
  );

  always_comb begin
    sel_res   = '0;
    sel_wb    = 1'b0;
    sel_legal = 1'b0;
    nxt_fl    = '0;
    if (op_is_arith(in_op)) begin
      sel_res   = ar_res;
      sel_wb    = (in_op != OP_CMP);
      sel_legal = 1'b1;
      nxt_fl.sf = ar_res[W-1];
      nxt_fl.zf = (ar_res == '0);
      nxt_fl.of = ar_ovf;
    end else if (op_is_logic(in_op)) begin
      sel_res   = lg_res;
      sel_wb    = 1'b1;
      sel_legal = 1'b1;
      nxt_fl.sf = lg_res[W-1];
      nxt_fl.zf = (lg_res == '0);
      nxt_fl.of = 1'b0;
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign flag_we  = accept && in_flag_we && sel_legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_wb     <= 1'b0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_result <= sel_res;
      out_wb     <= sel_wb;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  flagalu_flags u_flags (
    .clk(clk), .rst(rst), .we(flag_we), .nxt(nxt_fl), .cur(cur_fl)
  );

  flagalu_cond u_cond (
    .fl(cur_fl), .sel(cond_sel), .taken(cond_true)
  );

  assign flag_sf = cur_fl.sf;
  assign flag_zf = cur_fl.zf;
  assign flag_of = cur_fl.of;
endmodule

// File: rtl/flagalu_checker.sv
`timescale 1ns/1ps
module flagalu_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic [2:0]   in_op,
  input logic         in_flag_we,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_result,
  input logic         out_wb,
  input logic         flag_sf,
  input logic         flag_zf,
  input logic         flag_of
);
  import flagalu_pkg::*;

  logic acc;
  assign acc = in_valid && in_ready;

  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !flag_sf && !flag_zf && !flag_of));

  a_r4_zero_flag: assert property (@(posedge clk) disable iff (rst)
    (acc && in_flag_we && (op_is_arith(in_op) || op_is_logic(in_op)))
      |=> (flag_zf == (out_result == '0)));

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (acc && in_flag_we && op_is_logic(in_op))
      |=> (!flag_of && (flag_sf == out_result[W-1])));

  a_r6_flags_hold: assert property (@(posedge clk) disable iff (rst)
    !(acc && in_flag_we) |=> ($stable(flag_sf) && $stable(flag_zf) && $stable(flag_of)));

  a_r7_cmp_no_wb: assert property (@(posedge clk) disable iff (rst)
    (acc && (in_op == OP_CMP)) |=> (out_valid && !out_wb));

  a_r9_out_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_wb)));

  a_r10_bad_op: assert property (@(posedge clk) disable iff (rst)
    (acc && !op_is_arith(in_op) && !op_is_logic(in_op))
      |=> ($stable(flag_sf) && $stable(flag_zf) && $stable(flag_of) && !out_wb));
endmodule

bind flagalu_core flagalu_checker #(.W(W)) u_flagalu_checker (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_flag_we(in_flag_we), .out_valid(out_valid),
  .out_ready(out_ready), .out_result(out_result), .out_wb(out_wb),
  .flag_sf(flag_sf), .flag_zf(flag_zf), .flag_of(flag_of)
);

// File: tb/test_flagalu_core.sv
`timescale 1ns/1ps
module test_flagalu_core;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [2:0]   in_op = '0;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic         in_flag_we = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_result;
  logic         out_wb;
  logic         flag_sf, flag_zf, flag_of;
  logic [2:0]   cond_sel = '0;
  logic         cond_true;

  flagalu_core #(.W(W)) i_flagalu_core (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_flag_we(in_flag_we),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_wb(out_wb), .flag_sf(flag_sf), .flag_zf(flag_zf), .flag_of(flag_of),
    .cond_sel(cond_sel), .cond_true(cond_true)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic [W-1:0] res;
    logic         wb;
    string        tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 0;
  bit   bp_en = 0;
  int   bp_cnt = 0;
  logic m_sf = 0, m_zf = 0, m_of = 0;

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // back-pressure pattern, changed only just after a rising edge
  always @(posedge clk) begin
    #1;
    bp_cnt++;
    out_ready = bp_en ? ((bp_cnt % 3) != 0 && (bp_cnt % 7) != 2) : 1'b1;
  end

  // monitor: an item is taken at the next edge when valid and ready now
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      if (q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R9: unexpected output 0x%08h, expected none", out_result);
      end else begin
        exp_t e;
        e = q.pop_front();
        check({e.tag, " result"}, out_result, e.res);
        check({e.tag, " wb"}, {31'd0, out_wb}, {31'd0, e.wb});
      end
    end
  end

  task automatic drive(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic we, input string tag);
    longint ex;
    logic [W-1:0] r;
    logic wb, legal, sf, zf, of;
    exp_t e;
    legal = 1; wb = 1; of = 0;
    case (op)
      3'd0: ex = longint'($signed(a)) + longint'($signed(b));
      3'd1, 3'd5: ex = longint'($signed(a)) - longint'($signed(b));
      default: ex = 0;
    endcase
    case (op)
      3'd0, 3'd1, 3'd5: begin
        r  = ex[W-1:0];
        of = (ex != longint'($signed(r)));
        if (op == 3'd5) wb = 0;
      end
      3'd2: r = a & b;
      3'd3: r = a | b;
      3'd4: r = a ^ b;
      default: begin r = '0; wb = 0; legal = 0; end
    endcase
    sf = r[W-1];
    zf = (r == '0);
    e.res = r; e.wb = wb; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    in_op = op; in_a = a; in_b = b; in_flag_we = we; in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    if (we && legal) begin m_sf = sf; m_zf = zf; m_of = of; end
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic check_flags(input string tag);
    drain();
    @(negedge clk);
    #1;
    check({tag, " flags {sf,zf,of}"}, {29'd0, flag_sf, flag_zf, flag_of}, {29'd0, m_sf, m_zf, m_of});
  endtask

  task automatic check_conds(input string tag);
    logic less;
    logic exp;
    less = m_sf ^ m_of;
    for (int c = 0; c < 8; c++) begin
      case (c)
        0: exp = m_zf;
        1: exp = !m_zf;
        2: exp = less;
        3: exp = !less;
        4: exp = m_zf || less;
        5: exp = !m_zf && !less;
        default: exp = 1'b0;
      endcase
      cond_sel = 3'(c);
      #1;
      check($sformatf("%s R8 cond %0d", tag, c), {31'd0, cond_true}, {31'd0, exp});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 out_valid in reset", {31'd0, out_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 flags after reset", {29'd0, flag_sf, flag_zf, flag_of}, 32'd0);
    check("R9 in_ready idle", {31'd0, in_ready}, 32'd1);

    drive(3'd0, 32'd5, 32'd7, 1, "R2 add");
    check_flags("R4 add positive");
    drive(3'd0, 32'h7fff_ffff, 32'd1, 1, "R3 add max+1");
    check_flags("R3 add overflow");
    check_conds("after add overflow");
    drive(3'd2, 32'hf0f0_0000, 32'hff00_00ff, 1, "R5 and");
    check_flags("R5 and clears of");
    drive(3'd1, 32'd3, 32'd3, 1, "R2 sub equal");
    check_flags("R4 sub zero");
    check_conds("after zero");
    drive(3'd1, 32'h8000_0000, 32'd1, 1, "R3 sub min-1");
    check_flags("R3 sub overflow");
    drive(3'd5, 32'd2, 32'd5, 1, "R7 cmp");
    check_flags("R7 cmp flags");
    check_conds("after cmp less");
    drive(3'd5, 32'd9, 32'hffff_fffc, 1, "R7 cmp greater");
    check_flags("R7 cmp greater flags");
    check_conds("after cmp greater");
    drive(3'd4, 32'h1234_5678, 32'h1234_5678, 1, "R5 xor");
    check_flags("R4 xor zero");
    drive(3'd3, 32'h0000_0001, 32'h8000_0000, 1, "R5 or");
    check_flags("R5 or sign");
    drive(3'd1, 32'd0, 32'd0, 0, "R6 sub no we");
    check_flags("R6 flags held");
    drive(3'd6, 32'd1, 32'd1, 1, "R10 op6");
    drive(3'd7, 32'hffff_ffff, 32'd0, 1, "R10 op7");
    check_flags("R10 flags held");

    bp_en = 1;
    for (int i = 0; i < 24; i++) begin
      drive(3'(i % 6), 32'h1357_9bdf * (i + 1), 32'h0246_8ace ^ (i * 32'h1111_1111),
            logic'(i % 2), $sformatf("R9 burst %0d", i));
    end
    drain();
    bp_en = 0;
    check_flags("R9 burst final");
    repeat (4) @(negedge clk);
    check("R9 queue empty", 32'(q.size()), 32'd0);
    finish_run();
  end
endmodule